// File: doc/BRIEF.md
# External Pin Interrupt Request Unit

This block watches one external input pin and turns a qualified transition on it into an interrupt request flag. The pin is first brought into the clock domain with a two-flop synchronizer. Its level then has to hold steady for a minimum number of system clocks before the block accepts it. A 4-bit control register, written and read by the CPU, decides four things: whether the pin is listened to at all, which polarity counts as active, whether one edge or both edges count, and whether a qualified edge also fires a one-clock timer count-start strobe.

The request flag is set by a qualified edge. It is cleared either when the interrupt is acknowledged or when software runs a skip-style test of the flag, and that test returns the value the flag held before the clear. The interrupt request is raised only while the flag, the block's own enable and the global enable are all set. A level test reports whether the filtered pin currently sits at the polarity chosen in the register.

Changing the polarity or enable bits re-evaluates the filtered pin against the new setting. A transition produced that way is treated as an edge, the same as one on the pin.

Top module: `extint_req_unit`

## Requirements
- R1: After reset the control register reads 0000, and `req_flag`, `irq_req` and `tmr_start` are 0.
- R2: A new pin level is accepted only once it has been sampled for at least STABLE_CLKS (default 4) consecutive clocks. A level held for fewer clocks produces no flag. For a held change driven before clock edge k, the flag reads 1 after edge k+6 and 0 after edge k+5.
- R3: The control register is written with `ctl_wr_en`/`ctl_wr_data` and is always visible on `ctl_rd_data`. Bit 3 is the input enable (1 = enabled). Bit 2 is the polarity (0 = falling edge / low level, 1 = rising edge / high level). Bit 1 is the edge mode (0 = one edge, 1 = both edges). Bit 0 is the timer-start select (1 = selected).
- R4: With bit 3 = 1, bit 2 = 1 and bit 1 = 0, a low-to-high pin change sets the flag and a high-to-low change does not.
- R5: With bit 3 = 1, bit 2 = 0 and bit 1 = 0, a high-to-low pin change sets the flag and a low-to-high change does not.
- R6: With bit 3 = 1 and bit 1 = 1, a pin change in either direction sets the flag.
- R7: With bit 3 = 0, pin changes never set the flag and `lvl_match` is 0.
- R8: `irq_ack` clears the flag at the next clock. `flag_test` also clears it at the next clock, and in the same cycle `test_hit` shows the flag value from before the clear.
- R9: If an edge and a clear request fall in the same clock, the flag ends up set.
- R10: `irq_req` is 1 exactly when `req_flag`, `irq_en` and `gie` are all 1.
- R11: `lvl_match` is 1 when the input is enabled and the filtered pin equals bit 2.
- R12: When bit 0 = 1, `tmr_start` pulses high for one clock, in the cycle the flag is set by an edge. When bit 0 = 0, `tmr_start` stays 0.
- R13: A write to bit 2 or bit 3 that makes the filtered pin newly active counts as an edge and sets the flag two clocks after the write is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | External interrupt pin, asynchronous |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 4 | Control register write value |
| ctl_rd_data | output | 4 | Control register readback |
| flag_test | input | 1 | Skip-style flag test strobe; clears the flag |
| test_hit | output | 1 | Flag value seen by the current test |
| irq_ack | input | 1 | Interrupt acknowledge strobe; clears the flag |
| irq_en | input | 1 | This source's interrupt enable |
| gie | input | 1 | Global interrupt enable |
| req_flag | output | 1 | Interrupt request flag |
| irq_req | output | 1 | Interrupt request to the controller |
| lvl_match | output | 1 | Filtered pin at selected level |
| tmr_start | output | 1 | One-clock timer count-start strobe |

## Verification
The bench goes after the pulse-width boundary: a pulse held three clocks must be dropped and one held four clocks must be accepted. A filter that is off by one would either flag glitches or miss minimum-width pulses. It also lands an acknowledge in the very clock an edge arrives, where a design that lets the clear win loses the interrupt. It also rewrites the polarity and enable bits with the pin idle. A design that does not re-evaluate the pin against the new setting would leave the flag clear there. Seeded random segments mix configurations, directions and glitch widths, and compare the flag, the level test and the timer strobe with expectations derived from the mode bits.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int CTL_W = 4;

  // Field order matches the control register bit positions 3..0
  typedef struct packed {
    logic en;    // bit 3: pin input enable
    logic pol;   // bit 2: active polarity
    logic both;  // bit 1: both-edge mode
    logic tsel;  // bit 0: timer start select
  } ctl_t;
endpackage

// File: rtl/extint_sync_filter.sv
module extint_sync_filter #(
  parameter int STABLE_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic filt_lvl
);
  localparam int CNT_W = (STABLE_CLKS > 2) ? $clog2(STABLE_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CLKS - 1);

  logic s1, s2;
  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      filt_lvl <= 1'b0;
    end else if (s2 == filt_lvl) begin
      run_cnt <= '0;
    end else if (run_cnt == CNT_LAST) begin
      run_cnt  <= '0;
      filt_lvl <= s2;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R2
  filt_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_lvl != $past(filt_lvl)) |-> ($past(s2) == filt_lvl));
endmodule

// File: rtl/extint_edge_qual.sv
module extint_edge_qual
  import extint_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic filt_lvl,
  input  ctl_t ctl,
  output logic edge_ev,
  output logic lvl_match
);
  logic act_lvl, act_prev;

  // Active level folds polarity and enable, so register writes create edges
  always_comb begin
    act_lvl   = ctl.en & (ctl.pol ? filt_lvl : ~filt_lvl);
    lvl_match = act_lvl;
  end

  always_comb begin
    if (ctl.both) edge_ev = act_lvl ^ act_prev;
    else          edge_ev = act_lvl & ~act_prev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_prev <= 1'b0;
    else        act_prev <= act_lvl;
  end

  // R11
  lvl_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en |-> !lvl_match);
endmodule

// File: rtl/extint_req_flag.sv
module extint_req_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_ev,
  input  logic irq_ack,
  input  logic flag_test,
  input  logic tmr_sel,
  output logic req_flag,
  output logic tmr_start
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_flag  <= 1'b0;
      tmr_start <= 1'b0;
    end else begin
      tmr_start <= edge_ev & tmr_sel;
      if (edge_ev)                    req_flag <= 1'b1;
      else if (irq_ack || flag_test)  req_flag <= 1'b0;
    end
  end

  // R8
  test_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_test && !edge_ev) |=> !req_flag);
  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !edge_ev) |=> !req_flag);
endmodule

// File: rtl/extint_req_unit.sv
module extint_req_unit
  import extint_pkg::*;
#(
  parameter int STABLE_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wr_data,
  output logic [CTL_W-1:0] ctl_rd_data,
  input  logic             flag_test,
  output logic             test_hit,
  input  logic             irq_ack,
  input  logic             irq_en,
  input  logic             gie,
  output logic             req_flag,
  output logic             irq_req,
  output logic             lvl_match,
  output logic             tmr_start
);
  ctl_t ctl_q;
  logic filt_lvl;
  logic edge_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctl_q <= '0;
    else if (ctl_wr_en) ctl_q <= ctl_t'(ctl_wr_data);
  end

  assign ctl_rd_data = ctl_q;

  extint_sync_filter #(.STABLE_CLKS(STABLE_CLKS)) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .filt_lvl (filt_lvl)
  );

  extint_edge_qual u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .filt_lvl  (filt_lvl),
    .ctl       (ctl_q),
    .edge_ev   (edge_ev),
    .lvl_match (lvl_match)
  );

  extint_req_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_ev   (edge_ev),
    .irq_ack   (irq_ack),
    .flag_test (flag_test),
    .tmr_sel   (ctl_q.tsel),
    .req_flag  (req_flag),
    .tmr_start (tmr_start)
  );

  assign test_hit = flag_test & req_flag;
  assign irq_req  = req_flag & irq_en & gie;

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ev |=> req_flag);
  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.en && !$past(ctl_q.en)) |-> !edge_ev);
  // R12
  tmr_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_start |-> req_flag);
  // R10
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_flag |-> !irq_req);
endmodule

// File: tb/extint_req_unit_tb.sv
module extint_req_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_in = 1'b0;
  logic       ctl_wr_en = 1'b0;
  logic [3:0] ctl_wr_data = 4'h0;
  logic [3:0] ctl_rd_data;
  logic       flag_test = 1'b0;
  logic       test_hit;
  logic       irq_ack = 1'b0;
  logic       irq_en = 1'b0;
  logic       gie = 1'b0;
  logic       req_flag, irq_req, lvl_match, tmr_start;

  int n_checks = 0;
  int n_fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extint_req_unit u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
    .flag_test(flag_test), .test_hit(test_hit),
    .irq_ack(irq_ack), .irq_en(irq_en), .gie(gie),
    .req_flag(req_flag), .irq_req(irq_req), .lvl_match(lvl_match),
    .tmr_start(tmr_start)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [3:0] v);
    ctl_wr_en = 1'b1; ctl_wr_data = v;
    cyc(1);
    ctl_wr_en = 1'b0;
  endtask

  // Pulse the flag test; returns the value seen before the clear
  task automatic do_test(output logic hit);
    flag_test = 1'b1;
    #1 hit = test_hit;
    cyc(1);
    flag_test = 1'b0;
  endtask

  task automatic clear_flag();
    logic dummy;
    do_test(dummy);
  endtask

  // Expected flag after a settled pin change a -> b under a control value
  function automatic logic exp_flag(input logic [3:0] c, input logic a, input logic b);
    if (!c[3] || a == b) return 1'b0;
    if (c[1]) return 1'b1;
    return (b == c[2]);
  endfunction

  function automatic logic exp_lvl(input logic [3:0] c, input logic p);
    return c[3] && (p == c[2]);
  endfunction

  initial begin
    logic hit;
    void'($urandom(32'h5eed_0101));
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    chk("R1 ctl", ctl_rd_data, 4'h0);
    chk("R1 flag", {3'b0, req_flag}, 4'h0);
    chk("R1 irq", {3'b0, irq_req}, 4'h0);
    chk("R1 tmr", {3'b0, tmr_start}, 4'h0);

    // R3 readback
    wr_ctl(4'b1010); chk("R3 readback", ctl_rd_data, 4'b1010);
    wr_ctl(4'b0101); chk("R3 readback", ctl_rd_data, 4'b0101);

    // R4 rising mode with latency check for R2
    wr_ctl(4'b1100); cyc(10); clear_flag(); cyc(2);
    chk("R11 low at rising pol", {3'b0, lvl_match}, 4'h0);
    pin_in = 1'b1;
    cyc(6);
    chk("R2 flag not yet", {3'b0, req_flag}, 4'h0);
    chk("R11 high at rising pol", {3'b0, lvl_match}, 4'h1);
    cyc(1);
    chk("R2 R4 flag on rise", {3'b0, req_flag}, 4'h1);
    chk("R12 no tmr when bit0=0", {3'b0, tmr_start}, 4'h0);
    do_test(hit);
    chk("R8 test sees prior 1", {3'b0, hit}, 4'h1);
    chk("R8 test clears", {3'b0, req_flag}, 4'h0);
    pin_in = 1'b0; cyc(10);
    chk("R4 no flag on fall", {3'b0, req_flag}, 4'h0);
    do_test(hit);
    chk("R8 test sees prior 0", {3'b0, hit}, 4'h0);

    // R5 falling mode
    pin_in = 1'b1; cyc(10);
    wr_ctl(4'b1000); cyc(10); clear_flag(); cyc(2);
    pin_in = 1'b0; cyc(10);
    chk("R5 flag on fall", {3'b0, req_flag}, 4'h1);
    clear_flag();
    pin_in = 1'b1; cyc(10);
    chk("R5 no flag on rise", {3'b0, req_flag}, 4'h0);

    // R2 glitch widths in both-edge mode
    wr_ctl(4'b1110); cyc(10); clear_flag(); cyc(2);
    pin_in = 1'b0; cyc(3); pin_in = 1'b1; cyc(12);
    chk("R2 3-clock glitch dropped", {3'b0, req_flag}, 4'h0);
    pin_in = 1'b0; cyc(4); pin_in = 1'b1; cyc(12);
    chk("R2 R6 4-clock pulse accepted", {3'b0, req_flag}, 4'h1);

    // R10 interrupt gating
    irq_en = 1'b0; gie = 1'b1; #1 chk("R10 en off", {3'b0, irq_req}, 4'h0);
    irq_en = 1'b1; gie = 1'b0; #1 chk("R10 gie off", {3'b0, irq_req}, 4'h0);
    irq_en = 1'b1; gie = 1'b1; #1 chk("R10 all on", {3'b0, irq_req}, 4'h1);
    cyc(1);
    irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
    chk("R8 ack clears", {3'b0, req_flag}, 4'h0);
    chk("R10 drops with flag", {3'b0, irq_req}, 4'h0);

    // R9 set wins and R12 timer strobe
    wr_ctl(4'b1111); cyc(10); clear_flag(); cyc(2);
    pin_in = 1'b0; cyc(12);
    chk("R6 both fall", {3'b0, req_flag}, 4'h1);
    pin_in = 1'b1;
    cyc(6);
    irq_ack = 1'b1;
    cyc(1);
    irq_ack = 1'b0;
    chk("R9 set beats ack", {3'b0, req_flag}, 4'h1);
    chk("R12 tmr pulse", {3'b0, tmr_start}, 4'h1);
    cyc(1);
    chk("R12 tmr one clock", {3'b0, tmr_start}, 4'h0);
    irq_en = 1'b0; gie = 1'b0;

    // R7 disabled
    wr_ctl(4'b0110); cyc(10); clear_flag(); cyc(2);
    pin_in = 1'b0; cyc(10); pin_in = 1'b1; cyc(10);
    chk("R7 no flag disabled", {3'b0, req_flag}, 4'h0);
    chk("R7 no level disabled", {3'b0, lvl_match}, 4'h0);

    // R13 register writes create edges
    pin_in = 1'b0; cyc(10);
    wr_ctl(4'b1100); cyc(10); clear_flag(); cyc(2);
    chk("R13 idle before", {3'b0, req_flag}, 4'h0);
    ctl_wr_en = 1'b1; ctl_wr_data = 4'b1000;
    cyc(1); ctl_wr_en = 1'b0;
    cyc(1);
    chk("R13 polarity flip sets flag", {3'b0, req_flag}, 4'h1);
    wr_ctl(4'b0000); cyc(10); clear_flag(); cyc(2);
    ctl_wr_en = 1'b1; ctl_wr_data = 4'b1000;
    cyc(1); ctl_wr_en = 1'b0;
    cyc(1);
    chk("R13 enable sets flag", {3'b0, req_flag}, 4'h1);

    // Random segments
    for (int s = 0; s < 60; s++) begin
      logic [3:0] c;
      logic a, glitch;
      int w;
      c = 4'($urandom());
      a = pin_in;
      glitch = ($urandom() % 3) == 0;
      w = 1 + int'($urandom() % 3);
      wr_ctl(c); cyc(10); clear_flag(); cyc(2);
      if (glitch) begin
        pin_in = ~a; cyc(w); pin_in = a; cyc(12);
        chk("R2 random glitch", {3'b0, req_flag}, 4'h0);
      end else begin
        pin_in = ~a; cyc(12);
        chk("R4 R5 R6 R7 random edge", {3'b0, req_flag}, {3'b0, exp_flag(c, a, ~a)});
        chk("R11 random level", {3'b0, lvl_match}, {3'b0, exp_lvl(c, ~a)});
      end
      do_test(hit);
      chk("R8 random test", {3'b0, req_flag}, 4'h0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule